// File: doc/BRIEF.md
# Sequential Booth Multiplier (Radix-2, One Bit per Cycle)

This block multiplies two signed two's-complement operands by iterating over the multiplier one bit per clock. It has one working register. The multiplier sits in the low part of that register, above a guard bit that starts at zero. The upper field of the register accumulates partial sums. The block also keeps two words, prepared once when a job is accepted: the multiplicand aligned to the upper field, and its negation aligned the same way.

On every step the two lowest register bits form a Booth pair, made of the current multiplier bit and the bit below it:
- Pair 01 adds the prepared multiplicand word.
- Pair 10 adds the prepared negated word.
- Pairs 00 and 11 add nothing.

The carry out of the sum is dropped. The register then shifts right by one place, and its sign bit is copied into the vacated top position.

A start pulse seen while the block is idle captures both operands. After as many steps as the multiplier has bits, the block writes the signed product to a held output register and raises a one-cycle done pulse. The upper field is one bit wider than the multiplicand, so the most negative multiplicand can be negated without losing its sign.

Top module: `booth_seq_mult`

## Requirements
- R1: While rst_n is low at a clock edge, busy, done and product are all cleared to 0.
- R2: For any multiplicand and multiplier, including zero, -1 and alternating bit patterns, product equals their exact signed product as a two's-complement value of MCAND_W+MPLR_W bits.
- R3: Operands at the extremes of the range give the exact product. This covers the most negative value times itself, times -1 and times the most positive value.
- R4: A start accepted at clock edge k raises busy from edge k to edge k+MPLR_W. At edge k+MPLR_W busy falls and done rises for exactly one cycle, with the new product valid in that same cycle.
- R5: A start pulse that arrives while busy is high is ignored. It does not alter the running job, its result or its timing, and it never produces a done pulse of its own.
- R6: product changes only at the edge that raises done. At all other times it holds its value, including while a later job is running.
- R7: The operands are captured at the accepted start. Changing mcand or mplr while busy is high has no effect on the result.
- R8: With MCAND_W=4 and MPLR_W=4, 5 times -2 gives 8'hF6, -8 times -8 gives 8'h40, and -8 times 7 gives 8'hC8.
- R9: done and busy are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse requesting a multiply; accepted only while busy is low |
| mcand | input | MCAND_W | Signed multiplicand, captured on an accepted start |
| mplr | input | MPLR_W | Signed multiplier, captured on an accepted start |
| product | output | MCAND_W+MPLR_W | Signed product, held between done pulses |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when a new product is on product |

## Verification
A wrong Booth pair decode, a wrong negated word, or a sign bit lost in the shift leaves the register state wrong without any visible sign at the ports. The error first appears at the done pulse, MPLR_W cycles after the accepted start, as a product that differs from the signed reference. The extreme operand pairs and the -1 cases are included to expose faults in the negation and the sign extension. A step counter that is off by one shows up in the same cycle it takes effect: busy runs too long or too short, or done arrives on the wrong edge, and both are checked against the cycle of acceptance. A start that is wrongly accepted while busy shows up as an extra done pulse, or as a product of the wrong operands.

// File: rtl/booth_pkg.sv
// Package shared by the Booth multiplier modules.
// Holds the step operation chosen from a Booth bit pair.
package booth_pkg;

    // Operation applied to the working register in one step
    typedef enum logic [1:0] {
        BOOTH_HOLD = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_op_e;

endpackage : booth_pkg

// File: rtl/booth_recode.sv
// Booth pair decoder.
// Input: the two lowest bits of the working register, {current multiplier bit, bit below}.
// Assumes the bit below the multiplier LSB starts as a zero guard bit.
module booth_recode
    import booth_pkg::*;
(
    input  logic [1:0] pair,
    output booth_op_e  op
);

    // Map the bit pair to hold, add or subtract
    always_comb begin
        case (pair)
            2'b01:   op = BOOTH_ADD;
            2'b10:   op = BOOTH_SUB;
            default: op = BOOTH_HOLD;
        endcase
    end

endmodule : booth_recode

// File: rtl/booth_step.sv
// One Booth iteration: conditional add through a ripple carry chain,
// then an arithmetic shift right by one.
// Assumes add_word and sub_word already hold the aligned multiplicand and its negation.
// The carry out of the top bit is dropped.
module booth_step
    import booth_pkg::*;
#(
    parameter int W = 66
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] add_word,
    input  logic [W-1:0] sub_word,
    input  booth_op_e    op,
    output logic [W-1:0] nxt
);

    logic [W-1:0] addend;
    logic [W-1:0] sum;
    logic [W-1:0] carry;

    // Select the addend word for this step
    always_comb begin
        case (op)
            BOOTH_ADD: addend = add_word;
            BOOTH_SUB: addend = sub_word;
            default:   addend = '0;
        endcase
    end

    assign carry[0] = 1'b0;

    // Ripple carry chain, one full adder per bit
    for (genvar gi = 0; gi < W; gi++) begin : g_fa
        assign sum[gi] = acc[gi] ^ addend[gi] ^ carry[gi];
        if (gi < W - 1) begin : g_cy
            assign carry[gi+1] = (acc[gi] & addend[gi]) |
                                 (acc[gi] & carry[gi])  |
                                 (addend[gi] & carry[gi]);
        end
    end

    // Arithmetic shift right, copying the sign bit
    assign nxt = {sum[W-1], sum[W-1:1]};

endmodule : booth_step

// File: rtl/booth_ctrl.sv
// Sequencer for the Booth multiplier.
// Accepts start only when idle, counts STEPS iterations, and pulses done
// in the cycle after the last step.
// Assumes STEPS >= 1.
module booth_ctrl #(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic last_step,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

    logic [CNT_W-1:0] cnt;

    assign load      = start && !busy;
    assign last_step = busy && (cnt == LAST_CNT);

    // Track busy, the step count and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= last_step;
            if (load) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (last_step) begin
                    busy <= 1'b0;
                end
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule : booth_ctrl

// File: rtl/booth_seq_mult.sv
// Sequential radix-2 Booth multiplier, top level.
// Register layout, LSB first: guard bit, MPLR_W multiplier bits, and an
// MCAND_W+1 bit upper field. The extra upper bit lets the most negative
// multiplicand be negated without loss.
// The product is the register's bits above the guard, excluding the extra top bit.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int MCAND_W = 32,
    parameter int MPLR_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [MCAND_W-1:0]         mcand,
    input  logic [MPLR_W-1:0]          mplr,
    output logic [MCAND_W+MPLR_W-1:0]  product,
    output logic                       busy,
    output logic                       done
);

    localparam int EXT_W  = MCAND_W + 1;
    localparam int LOW_W  = MPLR_W + 1;
    localparam int ACC_W  = EXT_W + LOW_W;
    localparam int PROD_W = MCAND_W + MPLR_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_nxt;
    logic [ACC_W-1:0] add_word;
    logic [ACC_W-1:0] sub_word;
    logic [EXT_W-1:0] mcand_ext;
    logic [EXT_W-1:0] mcand_neg;
    logic             load;
    logic             last_step;
    booth_op_e        op;

    // Sign-extend the multiplicand and form its negation
    always_comb begin
        mcand_ext = {mcand[MCAND_W-1], mcand};
        mcand_neg = ~mcand_ext + 1'b1;
    end

    booth_ctrl #(
        .STEPS(MPLR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .last_step(last_step),
        .busy     (busy),
        .done     (done)
    );

    booth_recode u_recode (
        .pair(acc[1:0]),
        .op  (op)
    );

    booth_step #(
        .W(ACC_W)
    ) u_step (
        .acc     (acc),
        .add_word(add_word),
        .sub_word(sub_word),
        .op      (op),
        .nxt     (acc_nxt)
    );

    // Load operands on an accepted start, otherwise step while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            add_word <= '0;
            sub_word <= '0;
        end else if (load) begin
            acc      <= {{EXT_W{1'b0}}, mplr, 1'b0};
            add_word <= {mcand_ext, {LOW_W{1'b0}}};
            sub_word <= {mcand_neg, {LOW_W{1'b0}}};
        end else if (busy) begin
            acc <= acc_nxt;
        end
    end

    // Capture the finished product on the last step and hold it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product <= '0;
        end else if (last_step) begin
            product <= acc_nxt[PROD_W:1];
        end
    end

endmodule : booth_seq_mult

// File: rtl/booth_seq_mult_chk.sv
// Port-level checker for booth_seq_mult, attached with bind below.
// Counts the length of each busy run, so no deep $past is needed.
module booth_seq_mult_chk #(
    parameter int MCAND_W = 32,
    parameter int MPLR_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      busy,
    input logic                      done,
    input logic [MCAND_W+MPLR_W-1:0] product
);

    int unsigned run_len;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_len <= 0;
        end else begin
            run_len <= run_len + 1;
        end
    end

    // R4: a busy run never exceeds MPLR_W cycles
    p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < MPLR_W));

    // R4: done follows a busy run of exactly MPLR_W cycles
    p_done_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(run_len) == MPLR_W - 1));

    // R4: done lasts one cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: busy only falls together with done
    p_busy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6: product moves only in the done cycle
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

    // R9: done and busy exclusive
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

endmodule : booth_seq_mult_chk

bind booth_seq_mult booth_seq_mult_chk #(
    .MCAND_W(MCAND_W),
    .MPLR_W (MPLR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .product(product)
);

// File: tb/booth_seq_mult_bench.sv
`timescale 1ns/1ps
module booth_seq_mult_bench;

    localparam int XW = 32;
    localparam int YW = 32;
    localparam int PW = XW + YW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic signed [XW-1:0] a = '0;
    logic signed [YW-1:0] b = '0;
    logic [PW-1:0]        prod;
    logic                 busy, done;

    logic                 start2 = 1'b0;
    logic [3:0]           a2 = '0, b2 = '0;
    logic [7:0]           prod2;
    logic                 busy2, done2;

    booth_seq_mult #(.MCAND_W(XW), .MPLR_W(YW)) u_booth_seq_mult (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(a), .mplr(b),
        .product(prod), .busy(busy), .done(done));

    booth_seq_mult #(.MCAND_W(4), .MPLR_W(4)) u_small (
        .clk(clk), .rst_n(rst_n), .start(start2), .mcand(a2), .mplr(b2),
        .product(prod2), .busy(busy2), .done(done2));

    typedef struct {
        logic [PW-1:0] exp;
        int            acc_cyc;
        string         tag;
    } item_t;

    item_t sb[$];
    item_t it;
    int    checks = 0, fails = 0, cyc = 0;
    int    busy_run = 0, pushed = 0, seen = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: waits for idle, pulses start, pushes the expected result
    task automatic drive(input logic signed [XW-1:0] x, input logic signed [YW-1:0] y,
                         input string tag);
        logic signed [63:0] e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e = longint'(x) * longint'(y);
        start = 1'b1; a = x; b = y;
        sb.push_back('{exp: e, acc_cyc: cyc + 1, tag: tag});
        pushed++;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic small_mul(input logic [3:0] x, input logic [3:0] y, input logic [7:0] exp);
        @(negedge clk);
        start2 = 1'b1; a2 = x; b2 = y;
        @(negedge clk);
        start2 = 1'b0;
        while (!done2) @(negedge clk);
        check(prod2 == exp, "R8 small product", PW'(prod2), PW'(exp));
    endtask

    // Monitor: pops and compares on every done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                seen++;
                busy_run = 0;
                if (sb.size() == 0) begin
                    check(1'b0, "R5 unexpected done", prod, '0);
                end else begin
                    it = sb.pop_front();
                    check(prod == it.exp, it.tag, prod, it.exp);
                    check(cyc == it.acc_cyc + YW, "R4 done latency",
                          PW'(cyc), PW'(it.acc_cyc + YW));
                    check(!busy, "R9 busy during done", PW'(busy), '0);
                end
            end
            if (busy) busy_run++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R4 watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [PW-1:0] held;
        logic [31:0]   seed;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", PW'(busy), '0);
        check(done == 1'b0, "R1 done in reset", PW'(done), '0);
        check(prod == '0,   "R1 product in reset", prod, '0);
        rst_n = 1'b1;

        drive(32'sd5, -32'sd2, "R2 5*-2");
        drive(32'sd0, 32'sd123, "R2 zero mcand");
        drive(32'sd77, 32'sd0, "R2 zero mplr");
        drive(-32'sd1, -32'sd1, "R2 -1*-1");
        drive(-32'sd1, 32'sd7, "R2 -1*7");
        drive(32'sd123456789, -32'sd987654, "R2 mixed sign");
        drive(32'h55555555, 32'hAAAAAAAA, "R2 alternating");
        drive(32'h7fffffff, 32'h7fffffff, "R3 max*max");
        drive(32'h80000000, 32'h80000000, "R3 min*min");
        drive(32'h80000000, -32'sd1, "R3 min*-1");
        drive(32'h80000000, 32'h7fffffff, "R3 min*max");
        drive(32'h7fffffff, 32'h80000000, "R3 max*min");
        seed = 32'h1234_5678;
        for (int i = 0; i < 12; i++) begin
            logic [31:0] r1, r2;
            seed = seed * 32'd1664525 + 32'd1013904223; r1 = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; r2 = seed;
            drive(r1, r2, "R2 pseudo random");
        end
        drain();

        // R5 and R7: restart attempt and operand changes while busy
        drive(-32'sd300, 32'sd41, "R7 operands captured");
        repeat (5) @(negedge clk);
        start = 1'b1; a = 32'sd9; b = 32'sd9;
        @(negedge clk);
        start = 1'b0; a = -32'sd5; b = 32'sd1000;
        drain();
        repeat (YW + 4) @(negedge clk);
        check(seen == pushed, "R5 done count", PW'(seen), PW'(pushed));

        // R6: product holds while idle and while the next job runs
        held = prod;
        repeat (10) @(negedge clk);
        check(prod == held, "R6 hold idle", prod, held);
        drive(32'sd3, 32'sd3, "R2 3*3");
        repeat (10) @(negedge clk);
        check(prod == held, "R6 hold during busy", prod, held);
        drain();

        small_mul(4'd5, 4'hE, 8'hF6);
        small_mul(4'h8, 4'h8, 8'h40);
        small_mul(4'h8, 4'h7, 8'hC8);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule : booth_seq_mult_bench